// File: doc/BRIEF.md
# Crystal-Clocked Hardware Watchdog Timer

This block is a fixed-timeout watchdog clocked from the 32.768 kHz real-time-clock domain. It runs apart from any watchdog inside the processor. Firmware must restart the count by pulsing a refresh strobe more often than the timeout allows. A low wake level also holds the count in restart. No register bit can turn the watchdog off. Only two dedicated pins can: a debug-enable pin, and an input that reports the supply-tie debug condition.

If the count runs out without a restart, the block drives a system reset for a fixed start-up interval. It then waits one more cycle and releases the processor, which begins execution from address 0x0000. An overflow also sets a sticky status flag. The watchdog reset does not clear this flag. Firmware can clear it with a strobe, and the external reset pin clears it too. With the default parameters the timeout is 49152 cycles, which is 1.5 s, and the hold interval is 4100 cycles, which is about 125 ms.

Top module: `crystal_wdt`

## Requirements
- R1: While `rst_pin` is high and after it falls, `sys_rst` is 0, `cpu_run` is 1 and `ovf_flag` is 0, and the timeout count begins again from zero.
- R2: With the watchdog enabled, `wake` high and no refresh, `sys_rst` goes high in the cycle after LIMIT_CYCLES consecutive counting edges have been seen since the last restart.
- R3: `sys_rst` stays high for exactly HOLD_CYCLES cycles after an overflow.
- R4: `cpu_run` goes low in the same cycle that `sys_rst` rises. It stays low for one extra cycle after `sys_rst` falls, then returns to 1. `sys_rst` and `cpu_run` are never high together.
- R5: A refresh pulse (`kick`=1 at a clock edge) sets the count back to zero, so refreshes spaced fewer than LIMIT_CYCLES cycles apart never cause an overflow.
- R6: While `wake` is 0 the count is held at zero and no overflow can occur.
- R7: While `dbg_en` is 1 the watchdog is disabled: the count is held at zero and no overflow can occur.
- R8: While `tie_dis` is 1 the watchdog is disabled in the same way as in R7.
- R9: Each overflow sets `ovf_flag` to 1 in the cycle that `sys_rst` rises. The flag stays at 1 through the hold interval and afterwards.
- R10: A `clr_ovf` pulse clears `ovf_flag`. If a clear and an overflow fall on the same edge, the flag ends up at 1.
- R11: `kick` and `wake` have no effect while `sys_rst` or the release gap is active. The hold length and the release time do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz real-time-clock domain clock |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| kick | input | 1 | Refresh strobe from the firmware register write |
| wake | input | 1 | Internal wake level; 0 holds the count in restart |
| dbg_en | input | 1 | Debug-enable pin; 1 disables the watchdog |
| tie_dis | input | 1 | Supply-tie detect; 1 disables the watchdog |
| clr_ovf | input | 1 | Firmware strobe that clears the overflow flag |
| sys_rst | output | 1 | System reset issued on overflow |
| cpu_run | output | 1 | Processor run-release; 0 holds the processor in reset |
| ovf_flag | output | 1 | Sticky overflow status flag |

## Verification
Two functions can meet on one clock edge: the overflow that sets the status flag, and the firmware strobe that clears it. The bench tracks its own model of the count. It waits until the model's count sits one cycle short of the limit, then pulses `clr_ovf` on exactly the edge where the overflow fires. It expects `ovf_flag` to remain 1 while `sys_rst` rises. A second collision is a refresh strobe that lands during the reset hold. This is judged by checking that the hold still lasts its full length.

// File: rtl/crystal_wdt_pkg.sv
package crystal_wdt_pkg;
   typedef enum logic [1:0] {
      PH_RUN  = 2'd0,
      PH_HOLD = 2'd1,
      PH_GAP  = 2'd2
   } wdt_phase_e;
endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
   parameter int LIMIT_CYCLES = 49152
) (
   input  logic clk,
   input  logic rst_pin,
   input  logic restart,
   output logic expire
);
   localparam int CW = (LIMIT_CYCLES > 2) ? $clog2(LIMIT_CYCLES) : 1;
   localparam logic [CW-1:0] TERMINAL = CW'(LIMIT_CYCLES - 1);

   logic [CW-1:0] count_q;

   assign expire = !restart && (count_q == TERMINAL);

   always_ff @(posedge clk or posedge rst_pin) begin
      if (rst_pin) begin
         count_q <= '0;
      end else if (restart || expire) begin
         count_q <= '0;
      end else begin
         count_q <= count_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_hold_seq.sv
module wdt_hold_seq
   import crystal_wdt_pkg::*;
#(
   parameter int HOLD_CYCLES = 4100
) (
   input  logic clk,
   input  logic rst_pin,
   input  logic expire,
   output logic in_run,
   output logic sys_rst,
   output logic cpu_run
);
   localparam int HW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

   wdt_phase_e    phase_q;
   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or posedge rst_pin) begin
      if (rst_pin) begin
         phase_q <= PH_RUN;
         hold_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_RUN: begin
               hold_q <= '0;
               if (expire) phase_q <= PH_HOLD;
            end
            PH_HOLD: begin
               if (hold_q == HOLD_LAST) begin
                  phase_q <= PH_GAP;
                  hold_q  <= '0;
               end else begin
                  hold_q <= hold_q + 1'b1;
               end
            end
            default: begin
               phase_q <= PH_RUN;
               hold_q  <= '0;
            end
         endcase
      end
   end

   assign in_run  = (phase_q == PH_RUN);
   assign sys_rst = (phase_q == PH_HOLD);
   assign cpu_run = (phase_q == PH_RUN);
endmodule

// File: rtl/wdt_sticky_flag.sv
module wdt_sticky_flag (
   input  logic clk,
   input  logic rst_pin,
   input  logic set_evt,
   input  logic clr_evt,
   output logic flag
);
   always_ff @(posedge clk or posedge rst_pin) begin
      if (rst_pin) begin
         flag <= 1'b0;
      end else if (set_evt) begin
         flag <= 1'b1;
      end else if (clr_evt) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/crystal_wdt.sv
module crystal_wdt #(
   parameter int LIMIT_CYCLES    = 49152,
   parameter int HOLD_CYCLES     = 4100,
   parameter int DIS_SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_pin,
   input  logic kick,
   input  logic wake,
   input  logic dbg_en,
   input  logic tie_dis,
   input  logic clr_ovf,
   output logic sys_rst,
   output logic cpu_run,
   output logic ovf_flag
);
   if (LIMIT_CYCLES < 2) begin : g_bad_limit
      $error("LIMIT_CYCLES must be at least 2");
   end
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 1");
   end
   if (DIS_SYNC_STAGES < 0 || DIS_SYNC_STAGES > 4) begin : g_bad_sync
      $error("DIS_SYNC_STAGES must be within 0..4");
   end

   logic dis_raw, dis_eff, in_run, restart, expire;

   assign dis_raw = dbg_en | tie_dis;

   if (DIS_SYNC_STAGES == 0) begin : g_dis_direct
      assign dis_eff = dis_raw;
   end else begin : g_dis_sync
      logic [DIS_SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or posedge rst_pin) begin
         if (rst_pin) sync_q <= '0;
         else         sync_q <= {sync_q, dis_raw} >> 0;
      end
      assign dis_eff = sync_q[DIS_SYNC_STAGES-1] | dis_raw;
   end

   assign restart = dis_eff | kick | !wake | !in_run;

   wdt_tick_counter #(.LIMIT_CYCLES(LIMIT_CYCLES)) u_count (
      .clk     (clk),
      .rst_pin (rst_pin),
      .restart (restart),
      .expire  (expire)
   );

   wdt_hold_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
      .clk     (clk),
      .rst_pin (rst_pin),
      .expire  (expire),
      .in_run  (in_run),
      .sys_rst (sys_rst),
      .cpu_run (cpu_run)
   );

   wdt_sticky_flag u_flag (
      .clk     (clk),
      .rst_pin (rst_pin),
      .set_evt (expire),
      .clr_evt (clr_ovf),
      .flag    (ovf_flag)
   );
endmodule

// File: rtl/crystal_wdt_chk.sv
module crystal_wdt_chk (
   input logic clk,
   input logic rst_pin,
   input logic kick,
   input logic clr_ovf,
   input logic sys_rst,
   input logic cpu_run,
   input logic ovf_flag
);
   // R4
   excl_chk: assert property (@(posedge clk) disable iff (rst_pin)
      !(sys_rst && cpu_run));
   // R4
   gap_chk: assert property (@(posedge clk) disable iff (rst_pin)
      $fell(sys_rst) |-> !cpu_run);
   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (rst_pin)
      $rose(sys_rst) |-> ovf_flag);
   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst_pin)
      (ovf_flag && !clr_ovf) |=> ovf_flag);
   // R5
   kick_chk: assert property (@(posedge clk) disable iff (rst_pin)
      (kick && !sys_rst) |=> !$rose(sys_rst));
endmodule

bind crystal_wdt crystal_wdt_chk u_chk (
   .clk      (clk),
   .rst_pin  (rst_pin),
   .kick     (kick),
   .clr_ovf  (clr_ovf),
   .sys_rst  (sys_rst),
   .cpu_run  (cpu_run),
   .ovf_flag (ovf_flag)
);

// File: tb/crystal_wdt_test.sv
module crystal_wdt_test;
   localparam int CLK_PERIOD = 10;
   localparam int T = 20;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_pin = 1'b1, kick = 1'b0, wake = 1'b1;
   logic dbg_en = 1'b0, tie_dis = 1'b0, clr_ovf = 1'b0;
   logic sys_rst, cpu_run, ovf_flag;

   int checks = 0, fails = 0, cycles = 0;
   string req = "R1";
   int rst_high_len = 0;

   int m_cnt = 0, m_hold = 0, m_phase = 0;
   bit m_ovf = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crystal_wdt #(.LIMIT_CYCLES(T), .HOLD_CYCLES(H), .DIS_SYNC_STAGES(0)) uut (
      .clk(clk), .rst_pin(rst_pin), .kick(kick), .wake(wake),
      .dbg_en(dbg_en), .tie_dis(tie_dis), .clr_ovf(clr_ovf),
      .sys_rst(sys_rst), .cpu_run(cpu_run), .ovf_flag(ovf_flag)
   );

   // behavioural reference
   always @(posedge clk) begin
      cycles++;
      if (rst_pin) begin
         m_cnt = 0; m_hold = 0; m_phase = 0; m_ovf = 1'b0;
      end else if (m_phase == 0) begin
         bit held, fire;
         held = dbg_en || tie_dis || kick || !wake;
         fire = !held && (m_cnt == T - 1);
         if (clr_ovf) m_ovf = 1'b0;
         if (fire) begin
            m_ovf = 1'b1; m_phase = 1; m_hold = 0; m_cnt = 0;
         end else if (held) m_cnt = 0;
         else m_cnt = m_cnt + 1;
      end else if (m_phase == 1) begin
         if (clr_ovf) m_ovf = 1'b0;
         m_hold = m_hold + 1;
         if (m_hold == H) m_phase = 2;
      end else begin
         if (clr_ovf) m_ovf = 1'b0;
         m_phase = 0;
      end
   end

   task automatic cmp(input string r, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", r, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_pin) begin
         cmp(req, "sys_rst", sys_rst, m_phase == 1);
         cmp(req, "cpu_run", cpu_run, m_phase == 0);
         cmp(req, "ovf_flag", ovf_flag, m_ovf);
         if (sys_rst) rst_high_len++;
         else if (rst_high_len != 0) begin
            checks++;
            if (rst_high_len != H) begin
               fails++;
               $display("FAIL R3 hold length actual=%0d expected=%0d", rst_high_len, H);
            end
            rst_high_len = 0;
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      step(3);
      req = "R1";
      cmp("R1", "sys_rst in reset", sys_rst, 1'b0);
      cmp("R1", "cpu_run in reset", cpu_run, 1'b1);
      cmp("R1", "ovf_flag in reset", ovf_flag, 1'b0);
      rst_pin = 1'b0;
      step(2);

      req = "R2"; step(T + H + 6);            // overflow, hold, release (R2 R3 R4 R9)
      req = "R9"; step(5);

      req = "R5";
      for (int i = 0; i < 8; i++) begin
         step(T - 3); kick = 1'b1; step(1); kick = 1'b0;
      end

      req = "R10"; clr_ovf = 1'b1; step(1); clr_ovf = 1'b0; step(2);

      req = "R6"; wake = 1'b0; step(3 * T); wake = 1'b1; step(2);
      req = "R7"; dbg_en = 1'b1; step(3 * T); dbg_en = 1'b0; step(2);
      req = "R8"; tie_dis = 1'b1; step(3 * T); tie_dis = 1'b0; step(2);

      // R10: clear colliding with overflow; make flag 1 first
      req = "R10";
      while (m_phase != 0 || m_cnt != T - 1) step(1);
      step(1);
      while (m_phase != 0 || m_cnt != T - 1) step(1);
      clr_ovf = 1'b1; step(1); clr_ovf = 1'b0;
      cmp("R10", "set wins over clear", ovf_flag, 1'b1);

      // R11: kick and wake low during hold
      req = "R11";
      step(2); kick = 1'b1; wake = 1'b0; step(2); kick = 1'b0; wake = 1'b1;
      step(H + 4);

      // R1: reset pin clears sticky flag
      req = "R1";
      rst_pin = 1'b1; step(1);
      cmp("R1", "ovf_flag cleared by pin", ovf_flag, 1'b0);
      rst_pin = 1'b0; step(T - 2);
      cmp("R1", "count restarted by pin", sys_rst, 1'b0);
      step(T);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule